// File: doc/BRIEF.md
# Write Leveling Training Controller

This block runs the controller side of a write leveling pass for one memory device. On a start request it writes the device's first mode register with the leveling enable bit set. It then sends DQS pulses and reads back the one-bit clock sample that the device returns on DQ. A 0 means DQS reaches the device before the clock edge. A 1 means DQS reaches it after the edge. The controller steps its DQS delay tap upward and locks the tap where the reading first turns from 0 to 1. At that tap the clock and DQS arrive together.

Each reading is a majority vote over several pulses. Each pulse is followed by a fixed settling wait before the DQ bit is taken. This keeps a single noisy sample from moving the lock point. When the search ends, whether it locked or ran out of taps, the controller writes the mode register again with the enable bit cleared. It then raises a one-cycle done pulse. The chosen tap stays on the tap output for the delay line until the next training run. The delay line, the command path that carries the mode register writes, and the device are outside the block.

Top module: `wlvl_trainer`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, tap is 0 and mrw_req, dqs_pulse, done and fail are all 0.
- R2: Each run issues exactly two mode register writes. The first has mrw_lvl_en = 1 and comes before any DQS pulse. The second has mrw_lvl_en = 0, comes after the last DQS pulse and before done. At most one of mrw_req, dqs_pulse and done is high in any cycle.
- R3: Every tap visited receives exactly VOTES DQS pulses. The DQ bit for a pulse is taken SETTLE_CYC + 1 cycles after it, so two consecutive pulses are never closer than SETTLE_CYC + 2 cycles.
- R4: A tap reads as 1 only when a majority of its VOTES samples are 1. A single wrong sample per tap does not change the locked tap.
- R5: The tap starts at 0 and only ever increases by one between readings. The locked tap is the first tap that reads 1 after some earlier tap has read 0. Leading taps that read 1 before any 0 do not lock.
- R6: If the tap 2^TAP_W - 1 is read without a lock, fail goes to 1 and tap returns to 0. The disabling mode register write is still issued before done.
- R7: done is a single-cycle pulse. After it, tap and fail keep their values until the next accepted start.
- R8: A start request during a run has no effect. The run completes with its own result and the same two mode register writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin a training run; taken only when idle |
| dq_fb | input | 1 | Clock sample returned by the device on DQ (0 early, 1 late) |
| mrw_req | output | 1 | One-cycle request for a mode register write of the leveling enable bit |
| mrw_lvl_en | output | 1 | Value of the leveling enable bit for the write requested by mrw_req |
| dqs_pulse | output | 1 | One-cycle request for a DQS pulse |
| tap | output | TAP_W | Delay tap applied to the outgoing DQS |
| done | output | 1 | One-cycle pulse once leveling has been disabled |
| fail | output | 1 | Set when no 0-to-1 transition was found; held until the next start |

## Verification
The assertions rely on the command path accepting each mode register write in the cycle it is requested, and on dq_fb being valid when the controller takes its sample. The bench's device model meets both conditions. It changes dq_fb only in the cycle a DQS pulse appears, so the value is steady for the full settling wait. The early/late responses it builds are monotone edges, late-early-late shapes and one-flipped-sample noise. These are the patterns a real device presents. No case has two wrong samples at one tap, since that is outside what a majority of three can correct.

// File: rtl/wlvl_pkg.sv
// Shared types for the write leveling trainer.
// Assumes nothing beyond being compiled before the modules that import it.
package wlvl_pkg;

    // Training sequence states, in the order a run visits them.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_EN_WR,
        ST_EN_WAIT,
        ST_PULSE,
        ST_SETTLE,
        ST_SAMPLE,
        ST_DECIDE,
        ST_DIS_WR,
        ST_DIS_WAIT,
        ST_FIN
    } wlvl_state_e;

endpackage

// File: rtl/wlvl_timer.sv
// Down-counting wait timer. A load sets the count; expired is high once it
// reaches zero. Assumes load_val is one less than the wanted wait length.
module wlvl_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Load on request, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/wlvl_vote.sv
// Majority voter over VOTES feedback samples of one tap.
// Assumes clr is raised between taps and smp at most VOTES times per tap.
module wlvl_vote #(
    parameter int VOTES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic smp,
    input  logic bit_in,
    output logic last,
    output logic major
);
    localparam int VW = $clog2(VOTES + 1);

    logic [VW-1:0] seen_q;
    logic [VW-1:0] ones_q;

    // Count samples taken and samples that read 1.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            seen_q <= '0;
            ones_q <= '0;
        end else if (smp) begin
            seen_q <= seen_q + 1'b1;
            ones_q <= ones_q + VW'(bit_in);
        end
    end

    assign last  = (seen_q == VW'(VOTES - 1));
    assign major = (ones_q > VW'(VOTES / 2));
endmodule

// File: rtl/wlvl_trainer.sv
// Write leveling trainer: enables leveling, sweeps the DQS delay tap upward
// with voted early/late feedback, locks the first 0-to-1 tap, disables
// leveling and signals done. Assumes each mode register write request is
// taken by the command path in its cycle and that dq_fb is stable from a
// DQS pulse until the sample SETTLE_CYC + 1 cycles later.
module wlvl_trainer #(
    parameter int TAP_W      = 5,
    parameter int SETTLE_CYC = 4,
    parameter int MRD_CYC    = 6,
    parameter int VOTES      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dq_fb,
    output logic             mrw_req,
    output logic             mrw_lvl_en,
    output logic             dqs_pulse,
    output logic [TAP_W-1:0] tap,
    output logic             done,
    output logic             fail
);
    import wlvl_pkg::*;

    localparam int WAIT_MAX = (SETTLE_CYC > MRD_CYC) ? SETTLE_CYC : MRD_CYC;
    localparam int CNT_W    = $clog2(WAIT_MAX + 1);
    localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};

    wlvl_state_e      state_q, state_d;
    logic [TAP_W-1:0] tap_q;
    logic             seen0_q;
    logic             fail_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             vote_clr;
    logic             vote_last;
    logic             vote_major;
    logic             lock_hit;

    wlvl_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    wlvl_vote #(.VOTES(VOTES)) u_vote (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (vote_clr),
        .smp    (state_q == ST_SAMPLE),
        .bit_in (dq_fb),
        .last   (vote_last),
        .major  (vote_major)
    );

    // A tap locks when it reads late after an earlier tap read early.
    assign lock_hit = vote_major && seen0_q;

    // Timer loads: mode register delay after writes, settling after pulses.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = CNT_W'(MRD_CYC - 1);
        if (state_q == ST_EN_WR || state_q == ST_DIS_WR) begin
            tmr_load = 1'b1;
        end else if (state_q == ST_PULSE) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(SETTLE_CYC - 1);
        end
    end

    assign vote_clr = (state_q == ST_DECIDE) || (state_q == ST_IDLE);

    // Next-state logic of the training sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = ST_EN_WR;
            ST_EN_WR:    state_d = ST_EN_WAIT;
            ST_EN_WAIT:  if (tmr_expired) state_d = ST_PULSE;
            ST_PULSE:    state_d = ST_SETTLE;
            ST_SETTLE:   if (tmr_expired) state_d = ST_SAMPLE;
            ST_SAMPLE:   state_d = vote_last ? ST_DECIDE : ST_PULSE;
            ST_DECIDE:   state_d = (lock_hit || tap_q == TAP_MAX) ? ST_DIS_WR : ST_PULSE;
            ST_DIS_WR:   state_d = ST_DIS_WAIT;
            ST_DIS_WAIT: if (tmr_expired) state_d = ST_FIN;
            ST_FIN:      state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register plus tap, early-seen and fail bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tap_q   <= '0;
            seen0_q <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                tap_q   <= '0;
                seen0_q <= 1'b0;
                fail_q  <= 1'b0;
            end else if (state_q == ST_DECIDE && !lock_hit) begin
                if (tap_q == TAP_MAX) begin
                    fail_q <= 1'b1;
                    tap_q  <= '0;
                end else begin
                    tap_q   <= tap_q + 1'b1;
                    seen0_q <= seen0_q | ~vote_major;
                end
            end
        end
    end

    assign mrw_req    = (state_q == ST_EN_WR) || (state_q == ST_DIS_WR);
    assign mrw_lvl_en = (state_q == ST_EN_WR);
    assign dqs_pulse  = (state_q == ST_PULSE);
    assign done       = (state_q == ST_FIN);
    assign tap        = tap_q;
    assign fail       = fail_q;
endmodule

// File: rtl/wlvl_trainer_sva.sv
// Protocol checker for wlvl_trainer, observing its ports only.
// Assumes the bound instance uses the same TAP_W and SETTLE_CYC.
module wlvl_trainer_sva #(
    parameter int TAP_W      = 5,
    parameter int SETTLE_CYC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             mrw_req,
    input logic             mrw_lvl_en,
    input logic             dqs_pulse,
    input logic [TAP_W-1:0] tap,
    input logic             done,
    input logic             fail
);
    localparam int GAP_MIN = SETTLE_CYC + 2;
    localparam int GW      = $clog2(GAP_MIN + 1);

    logic          lvl_q;
    logic          held_q;
    logic [GW-1:0] gap_q;

    // Track the leveling enable bit as last written to the device.
    always_ff @(posedge clk) begin
        if (!rst_n)       lvl_q <= 1'b0;
        else if (mrw_req) lvl_q <= mrw_lvl_en;
    end

    // Track the hold window from done until the next start.
    always_ff @(posedge clk) begin
        if (!rst_n)     held_q <= 1'b0;
        else if (done)  held_q <= 1'b1;
        else if (start) held_q <= 1'b0;
    end

    // Count cycles since the last DQS pulse, saturating at the minimum gap.
    always_ff @(posedge clk) begin
        if (!rst_n)                   gap_q <= GW'(GAP_MIN);
        else if (dqs_pulse)           gap_q <= GW'(1);
        else if (gap_q < GW'(GAP_MIN)) gap_q <= gap_q + 1'b1;
    end

    assert_pulse_while_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dqs_pulse |-> lvl_q);
    assert_one_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mrw_req, dqs_pulse, done}));
    assert_pulse_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dqs_pulse |-> (gap_q >= GW'(GAP_MIN)));
    assert_tap_steps_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tap != $past(tap)) |-> (tap == TAP_W'($past(tap) + 1'b1) || tap == '0));
    assert_fail_tap_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (tap == '0));
    assert_done_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !lvl_q);
    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_tap_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && !start) |=> $stable(tap));
endmodule

bind wlvl_trainer wlvl_trainer_sva #(
    .TAP_W      (TAP_W),
    .SETTLE_CYC (SETTLE_CYC)
) u_wlvl_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mrw_req    (mrw_req),
    .mrw_lvl_en (mrw_lvl_en),
    .dqs_pulse  (dqs_pulse),
    .tap        (tap),
    .done       (done),
    .fail       (fail)
);

// File: tb/test_wlvl_trainer.sv
`timescale 1ns/1ps
// Bench for wlvl_trainer: a vector table of device responses walked by one
// loop, then directed reset tests. The device model lives in run_case.
module test_wlvl_trainer;
    localparam int TAP_W      = 5;
    localparam int SETTLE_CYC = 4;
    localparam int MRD_CYC    = 6;
    localparam int VOTES      = 3;
    localparam int MAXTAP     = (1 << TAP_W) - 1;
    localparam int NVEC       = 8;

    // Fields: early-from tap, late-from tap, noisy, expected tap, expected fail, start poke.
    // The device answers 1 when tap < early-from or tap >= late-from.
    localparam int VEC [0:NVEC-1][0:5] = '{
        '{0,  5, 0,  5, 0, 0},
        '{0,  1, 0,  1, 0, 0},
        '{3, 10, 0, 10, 0, 0},
        '{0,  7, 1,  7, 0, 0},
        '{0, 12, 0, 12, 0, 1},
        '{0, 31, 0, 31, 0, 0},
        '{0, 32, 0,  0, 1, 0},
        '{0,  0, 0,  0, 1, 0}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start;
    logic             dq_fb;
    logic             mrw_req;
    logic             mrw_lvl_en;
    logic             dqs_pulse;
    logic [TAP_W-1:0] tap;
    logic             done;
    logic             fail;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    wlvl_trainer #(
        .TAP_W(TAP_W), .SETTLE_CYC(SETTLE_CYC), .MRD_CYC(MRD_CYC), .VOTES(VOTES)
    ) i_wlvl_trainer (
        .clk(clk), .rst_n(rst_n), .start(start), .dq_fb(dq_fb),
        .mrw_req(mrw_req), .mrw_lvl_en(mrw_lvl_en), .dqs_pulse(dqs_pulse),
        .tap(tap), .done(done), .fail(fail)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // One training run with the device model answering each DQS pulse.
    task automatic run_case(input int pre, input int thr, input int noisy,
                            input int exp_tap, input int exp_fail, input int poke);
        int mr_n = 0;
        int pulses = 0;
        int bad_order = 0;
        int en1 = -1;
        int en2 = -1;
        int poked = 0;
        int exp_pulses;
        bit got_done = 1'b0;
        bit fb;
        string tap_tag;
        exp_pulses = VOTES * ((exp_fail != 0 ? MAXTAP : exp_tap) + 1);
        tap_tag = (noisy != 0) ? "R4 tap" : "R5 tap";
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 0; cyc < 5000 && !got_done; cyc++) begin
            start = 1'b0;
            if (mrw_req) begin
                mr_n++;
                if (mr_n == 1) en1 = int'(mrw_lvl_en);
                if (mr_n == 2) en2 = int'(mrw_lvl_en);
            end
            if (dqs_pulse) begin
                if (mr_n != 1) bad_order++;
                fb = (int'(tap) < pre) || (int'(tap) >= thr);
                if (noisy != 0 && (pulses % VOTES) == 0) fb = ~fb;
                dq_fb = fb;
                pulses++;
                if (poke != 0 && pulses == 10 && poked == 0) begin
                    start = 1'b1;   // R8: request while busy
                    poked = 1;
                end
            end
            if (done) begin
                got_done = 1'b1;
                chk(mr_n == 2, "R2 disable before done", mr_n, 2);
            end else begin
                @(negedge clk);
            end
        end
        chk(got_done, "R7 done seen", int'(got_done), 1);
        chk(int'(tap) == exp_tap, tap_tag, int'(tap), exp_tap);
        chk(int'(fail) == exp_fail, "R6 fail flag", int'(fail), exp_fail);
        chk(mr_n == 2, (poke != 0) ? "R8 write count" : "R2 write count", mr_n, 2);
        chk(en1 == 1 && en2 == 0, "R2 enable then disable", en1 * 10 + en2, 10);
        chk(bad_order == 0, "R2 pulses inside enable window", bad_order, 0);
        chk(pulses == exp_pulses, "R3 pulses per tap", pulses, exp_pulses);
        // R7: done lasts one cycle, tap and fail hold while idle.
        @(negedge clk);
        chk(done == 1'b0, "R7 done single cycle", int'(done), 0);
        repeat (5) @(negedge clk);
        chk(int'(tap) == exp_tap && int'(fail) == exp_fail, "R7 result held",
            int'(tap), exp_tap);
        chk(!mrw_req && !dqs_pulse, "R7 idle after done", int'(mrw_req), 0);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        dq_fb = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(tap == '0 && !fail, "R1 reset tap/fail", int'(tap), 0);
        chk(!mrw_req && !dqs_pulse && !done, "R1 reset requests",
            int'({mrw_req, dqs_pulse, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mrw_req && !dqs_pulse && !done && tap == '0, "R1 after release",
            int'({mrw_req, dqs_pulse, done}), 0);

        for (int v = 0; v < NVEC; v++) begin
            run_case(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
            repeat (2) @(negedge clk);
        end

        // R1: reset clears a held fail result.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fail == 1'b0 && tap == '0, "R1 reset clears fail", int'(fail), 0);

        // R1: reset in the middle of a sweep returns to idle.
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (60) begin
            if (dqs_pulse) dq_fb = (int'(tap) >= 20);
            @(negedge clk);
        end
        chk(tap != '0, "R5 sweep advanced", int'(tap), 1);
        rst_n = 1'b0;
        @(negedge clk);
        chk(tap == '0 && !mrw_req && !dqs_pulse && !done, "R1 mid-run reset",
            int'(tap), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!mrw_req && !dqs_pulse, "R1 stays idle", int'({mrw_req, dqs_pulse}), 0);

        // Recovery run after the interrupted one.
        run_case(0, 3, 0, 3, 0, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule